// File: doc/BRIEF.md
# Parallel SAR Converter Sequencer

This block sits on the host side of a 12-bit successive-approximation converter that has a parallel output bus. It drives the active-low read/convert strobe and the active-low chip select. It watches the converter's BUSY line and latches the result word from the parallel bus once the converter signals completion. Each result is handed on as a sign-extended sample over a valid/ready stream.

Conversions start in one of two ways. In single-shot mode each one-cycle request pulse starts one conversion. In free-running mode a new conversion starts as soon as the minimum start-to-start spacing allows. Chip select can be sequenced by the block, or held low permanently so that read/convert alone controls the converter. All minimum times are enforced as whole clock cycles through parameters. A BUSY line that never signals completion ends the attempt and leaves a sticky timeout flag. While a conversion is in flight, a quiet indication tells the host to keep its shared data lines still.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, conv_no_o and cs_no_o are 1, quiet_o is 0, and smp_valid_o, overrun_o and timeout_o are 0.
- R2: For each conversion, conv_no_o and cs_no_o are both low for exactly PULSE_CYC cycles (default 4).
- R3: When chip select is sequenced (cs_tied_i = 0), conv_no_o falls SETUP_CYC cycles (default 1) before cs_no_o falls. When cs_tied_i = 1, cs_no_o stays 0 for the whole time.
- R4: Two falling edges of conv_no_o are never closer than SPACING_CYC cycles (default 166).
- R5: The bus word is latched on the second clock edge after the edge at which the two-stage synchronized BUSY is first seen high. smp_valid_o therefore rises 4 cycles after BUSY rises at the pin. The word is read as two's complement, and bit 11 is copied into bits 15:12 of smp_data_o.
- R6: While smp_valid_o = 1 and smp_ready_i = 0, smp_valid_o stays high and smp_data_o stays unchanged, unless an overrun replaces the sample. smp_valid_o drops after a cycle with smp_ready_i = 1 and no new capture.
- R7: A capture that arrives while a sample is valid and not accepted replaces that sample and sets overrun_o. overrun_o stays set until reset.
- R8: If BUSY does not rise within TIMEOUT_CYC cycles (default 200) of the start of the convert pulse, the block returns to idle with both strobes high and delivers no sample. It also sets timeout_o, which stays set until reset.
- R9: In single-shot mode (free_run_i = 0), each start_i pulse produces exactly one conversion. In free-running mode, conversions repeat every SPACING_CYC cycles exactly.
- R10: quiet_o is 1 from the launch of a conversion until its capture or timeout. It is 0 whenever the block is idle.
- R11: A start_i pulse received during a conversion is held. It launches a conversion exactly SPACING_CYC cycles after the previous launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| free_run_i | input | 1 | 1: free-running conversions, 0: single-shot |
| cs_tied_i | input | 1 | 1: chip select held low permanently |
| start_i | input | 1 | One-cycle conversion request (single-shot mode) |
| busy_i | input | 1 | Converter BUSY line, asynchronous |
| bus_i | input | 12 | Converter parallel data bus |
| conv_no_o | output | 1 | Read/convert strobe, low starts a conversion |
| cs_no_o | output | 1 | Chip select, active low |
| quiet_o | output | 1 | Conversion in flight, keep host data lines still |
| smp_valid_o | output | 1 | Sample valid |
| smp_ready_i | input | 1 | Sample accepted by the sink |
| smp_data_o | output | 16 | Sign-extended conversion result |
| overrun_o | output | 1 | Sticky: an unaccepted sample was overwritten |
| timeout_o | output | 1 | Sticky: BUSY never signalled completion |

## Verification
The assertions assume the mode inputs change only while the block is idle. They also assume that BUSY rises only after it has fallen following a start, and that the bus word is stable from the BUSY rise through the capture edge. The bench converter model respects all three. It drives the bus only when read/convert is high, chip select is low and BUSY is high. It lowers BUSY a few cycles after it sees both strobes low, and raises it after a fixed conversion time. Mode inputs are changed only between scenarios, after the block has gone idle.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_WAIT,
    ST_CAPT
  } seq_state_e;
endpackage

// File: rtl/sar_busy_sync.sv
module sar_busy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  // idle level of BUSY is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], busy_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_ctrl_pkg::*;
#(
  parameter int SETUP_CYC   = 1,
  parameter int PULSE_CYC   = 4,
  parameter int SPACING_CYC = 166,
  parameter int CAPTURE_DLY = 2,
  parameter int TIMEOUT_CYC = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic free_i,
  input  logic tied_i,
  input  logic start_i,
  input  logic busy_rise_i,
  output logic conv_no_o,
  output logic cs_no_o,
  output logic quiet_o,
  output logic cap_o,
  output logic timeout_o
);
  localparam int PH_W  = $clog2(SETUP_CYC + PULSE_CYC + CAPTURE_DLY + 1);
  localparam int GAP_W = $clog2(SPACING_CYC + 1);
  localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);
  localparam bit USE_SETUP = (SETUP_CYC > 0);
  localparam logic [PH_W-1:0]  SETUP_LAST = PH_W'((SETUP_CYC > 0) ? SETUP_CYC - 1 : 0);
  localparam logic [PH_W-1:0]  PULSE_LAST = PH_W'(PULSE_CYC - 1);
  localparam logic [PH_W-1:0]  CAP_LAST   = PH_W'(CAPTURE_DLY - 2);
  localparam logic [GAP_W-1:0] GAP_MIN    = GAP_W'(SPACING_CYC);
  localparam logic [TMO_W-1:0] TMO_LAST   = TMO_W'(TIMEOUT_CYC);

  seq_state_e       state_q, nxt;
  logic [PH_W-1:0]  ph_q;
  logic [GAP_W-1:0] gap_q;
  logic [TMO_W-1:0] tmo_q;
  logic             pend_q;
  logic             launch, tmo_evt, cap;
  logic             conv_q, cs_q, quiet_q, tmo_flag_q;
  logic             gap_ok;

  assign gap_ok = (gap_q >= GAP_MIN);

  always_comb begin
    nxt     = state_q;
    launch  = 1'b0;
    tmo_evt = 1'b0;
    cap     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (gap_ok && (free_i || pend_q)) begin
          launch = 1'b1;
          nxt    = (USE_SETUP && !tied_i) ? ST_SETUP : ST_PULSE;
        end
      end
      ST_SETUP: if (ph_q == SETUP_LAST) nxt = ST_PULSE;
      ST_PULSE: if (ph_q == PULSE_LAST) nxt = ST_WAIT;
      ST_WAIT: begin
        if (busy_rise_i) begin
          nxt = ST_CAPT;
        end else if (tmo_q == TMO_LAST) begin
          tmo_evt = 1'b1;
          nxt     = ST_IDLE;
        end
      end
      ST_CAPT: begin
        if (ph_q == CAP_LAST) begin
          cap = 1'b1;
          nxt = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
    end else begin
      state_q <= nxt;
      ph_q    <= (nxt != state_q) ? '0 : ph_q + 1'b1;
    end
  end

  // start-to-start spacing, measured from the falling read/convert edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= GAP_MIN;
    end else if (launch) begin
      gap_q <= GAP_W'(1);
    end else if (!gap_ok) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // completion watchdog, counted from entry into the convert pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmo_q <= '0;
    end else if (nxt == ST_PULSE && state_q != ST_PULSE) begin
      tmo_q <= '0;
    end else if ((state_q == ST_PULSE || state_q == ST_WAIT) && tmo_q != TMO_LAST) begin
      tmo_q <= tmo_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
    end else if (free_i) begin
      pend_q <= 1'b0;
    end else if (launch) begin
      pend_q <= start_i;
    end else if (start_i) begin
      pend_q <= 1'b1;
    end
  end

  // strobes registered from the next state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_q     <= 1'b1;
      cs_q       <= 1'b1;
      quiet_q    <= 1'b0;
      tmo_flag_q <= 1'b0;
    end else begin
      conv_q  <= !(nxt == ST_SETUP || nxt == ST_PULSE);
      cs_q    <= !(nxt == ST_PULSE || nxt == ST_WAIT || nxt == ST_CAPT);
      quiet_q <= (nxt != ST_IDLE);
      if (tmo_evt) tmo_flag_q <= 1'b1;
    end
  end

  assign conv_no_o = conv_q;
  assign cs_no_o   = tied_i ? 1'b0 : cs_q;
  assign quiet_o   = quiet_q;
  assign cap_o     = cap;
  assign timeout_o = tmo_flag_q;
endmodule

// File: rtl/sar_out_stage.sv
module sar_out_stage #(
  parameter int DATA_W = 12,
  parameter int OUT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] raw_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [OUT_W-1:0]  data_o,
  output logic              overrun_o
);
  localparam int EXT_W = OUT_W - DATA_W;

  logic             valid_q, ovr_q;
  logic [OUT_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
      data_q  <= '0;
    end else if (cap_i) begin
      data_q  <= {{EXT_W{raw_i[DATA_W-1]}}, raw_i};
      valid_q <= 1'b1;
      if (valid_q && !ready_i) ovr_q <= 1'b1;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o   = valid_q;
  assign data_o    = data_q;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int DATA_W      = 12,
  parameter int OUT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int SETUP_CYC   = 1,
  parameter int PULSE_CYC   = 4,
  parameter int SPACING_CYC = 166,
  parameter int CAPTURE_DLY = 2,
  parameter int TIMEOUT_CYC = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              free_run_i,
  input  logic              cs_tied_i,
  input  logic              start_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic              conv_no_o,
  output logic              cs_no_o,
  output logic              quiet_o,
  output logic              smp_valid_o,
  input  logic              smp_ready_i,
  output logic [OUT_W-1:0]  smp_data_o,
  output logic              overrun_o,
  output logic              timeout_o
);
  logic busy_rise;
  logic cap;

  sar_busy_sync #(
    .STAGES(SYNC_STAGES)
  ) i_busy_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .busy_i(busy_i),
    .rise_o(busy_rise)
  );

  sar_seq #(
    .SETUP_CYC  (SETUP_CYC),
    .PULSE_CYC  (PULSE_CYC),
    .SPACING_CYC(SPACING_CYC),
    .CAPTURE_DLY(CAPTURE_DLY),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .free_i     (free_run_i),
    .tied_i     (cs_tied_i),
    .start_i    (start_i),
    .busy_rise_i(busy_rise),
    .conv_no_o  (conv_no_o),
    .cs_no_o    (cs_no_o),
    .quiet_o    (quiet_o),
    .cap_o      (cap),
    .timeout_o  (timeout_o)
  );

  sar_out_stage #(
    .DATA_W(DATA_W),
    .OUT_W (OUT_W)
  ) i_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    (cap),
    .raw_i    (bus_i),
    .ready_i  (smp_ready_i),
    .valid_o  (smp_valid_o),
    .data_o   (smp_data_o),
    .overrun_o(overrun_o)
  );
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int DATA_W      = 12,
  parameter int OUT_W       = 16,
  parameter int PULSE_CYC   = 4,
  parameter int SPACING_CYC = 166
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_tied_i,
  input logic             conv_no_o,
  input logic             cs_no_o,
  input logic             quiet_o,
  input logic             smp_valid_o,
  input logic             smp_ready_i,
  input logic [OUT_W-1:0] smp_data_o,
  input logic             overrun_o,
  input logic             timeout_o
);
  localparam int GAP_W = $clog2(SPACING_CYC + 1);
  localparam int EXT_N = OUT_W - DATA_W + 1;

  logic        both_low;
  logic [15:0] low_cnt;
  logic [GAP_W-1:0] gap_cnt;
  logic        conv_d;

  assign both_low = !conv_no_o && !cs_no_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt <= '0;
      gap_cnt <= GAP_W'(SPACING_CYC);
      conv_d  <= 1'b1;
    end else begin
      conv_d  <= conv_no_o;
      low_cnt <= both_low ? ((low_cnt == 16'hFFFF) ? low_cnt : low_cnt + 1'b1) : '0;
      if (conv_d && !conv_no_o) gap_cnt <= GAP_W'(1);
      else if (gap_cnt != GAP_W'(SPACING_CYC)) gap_cnt <= gap_cnt + 1'b1;
    end
  end

  // R2
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(both_low) |-> (low_cnt >= 16'(PULSE_CYC)));

  // R3
  setup_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cs_no_o) && !cs_tied_i) |-> (!conv_no_o && $past(!conv_no_o)));

  // R4
  spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_d && !conv_no_o) |-> (gap_cnt >= GAP_W'(SPACING_CYC)));

  // R5
  sign_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |-> (($countones(smp_data_o[OUT_W-1:DATA_W-1]) == 0) ||
                     ($countones(smp_data_o[OUT_W-1:DATA_W-1]) == EXT_N)));

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_o && !smp_ready_i) |=> (smp_valid_o && ($stable(smp_data_o) || overrun_o)));

  // R7
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  // R8
  timeout_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> timeout_o);

  // R10
  quiet_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !quiet_o |-> (conv_no_o && (cs_no_o || cs_tied_i)));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(
  .DATA_W     (DATA_W),
  .OUT_W      (OUT_W),
  .PULSE_CYC  (PULSE_CYC),
  .SPACING_CYC(SPACING_CYC)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_tied_i  (cs_tied_i),
  .conv_no_o  (conv_no_o),
  .cs_no_o    (cs_no_o),
  .quiet_o    (quiet_o),
  .smp_valid_o(smp_valid_o),
  .smp_ready_i(smp_ready_i),
  .smp_data_o (smp_data_o),
  .overrun_o  (overrun_o),
  .timeout_o  (timeout_o)
);

// File: tb/test_sar_conv_ctrl.sv
module test_sar_conv_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        free_run = 1'b0, cs_tied = 1'b0, start = 1'b0, busy = 1'b1, ready = 1'b0;
  logic [11:0] bus, bus_word = '0;
  logic        conv_n, cs_n, quiet, valid, overrun, timeout;
  logic [15:0] data;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  bit model_en = 1;
  int model_n = 0, busy_rise_cyc = 0;
  int last_rc_fall = -100000, last_gap = 0, last_setup = 0, last_pw = 0, run_len = 0, n_falls = 0;
  bit rc_prev = 1, cs_prev = 1, cs_high_seen = 0, quiet_seen = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  sar_conv_ctrl i_sar_conv_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .free_run_i(free_run), .cs_tied_i(cs_tied),
    .start_i(start), .busy_i(busy), .bus_i(bus), .conv_no_o(conv_n), .cs_no_o(cs_n),
    .quiet_o(quiet), .smp_valid_o(valid), .smp_ready_i(ready), .smp_data_o(data),
    .overrun_o(overrun), .timeout_o(timeout)
  );

  function automatic logic [11:0] word_of(int n);
    if (n == 0) return 12'h7FF;
    if (n == 1) return 12'h800;
    return 12'(n * 693) ^ 12'h0C3;
  endfunction

  function automatic int sx(logic [11:0] w);
    return int'({{4{w[11]}}, w});
  endfunction

  assign bus = (conv_n && !cs_n && busy) ? bus_word : 12'h000;

  // converter model
  initial begin
    forever begin
      @(negedge clk);
      if (model_en && rst_n && !conv_n && !cs_n) begin
        bus_word = word_of(model_n);
        model_n++;
        repeat (3) @(negedge clk);
        busy = 1'b0;
        repeat (60) @(negedge clk);
        busy = 1'b1;
        busy_rise_cyc = cyc;
      end
    end
  end

  // strobe monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rc_prev && !conv_n) begin
        last_gap = cyc - last_rc_fall;
        last_rc_fall = cyc;
        n_falls++;
      end
      if (cs_prev && !cs_n) last_setup = cyc - last_rc_fall;
      if (!conv_n && !cs_n) run_len++;
      else if (run_len != 0) begin
        last_pw = run_len;
        run_len = 0;
      end
      if (cs_n) cs_high_seen = 1;
      if (quiet) quiet_seen = 1;
      rc_prev = conv_n;
      cs_prev = cs_n;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_valid(string req);
    int k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!valid && k < 400);
    chk(valid, req, 0, 1);
  endtask

  task automatic t_reset();
    chk(conv_n == 1'b1 && cs_n == 1'b1, "R1 strobes", int'({conv_n, cs_n}), 3);
    chk(!valid && !overrun && !timeout, "R1 flags", int'({valid, overrun, timeout}), 0);
    chk(!quiet, "R1 R10 quiet", int'(quiet), 0);
  endtask

  task automatic t_single();
    int n0 = n_falls;
    logic [15:0] held;
    ready = 1'b0;
    quiet_seen = 0;
    pulse_start();
    wait_valid("R9 single sample");
    chk(cyc - busy_rise_cyc == 4, "R5 capture delay", cyc - busy_rise_cyc, 4);
    chk(int'(data) == sx(12'h7FF), "R5 positive word", int'(data), sx(12'h7FF));
    chk(last_pw == 4, "R2 pulse width", last_pw, 4);
    chk(last_setup == 1, "R3 setup", last_setup, 1);
    chk(quiet_seen && !quiet && conv_n, "R10 quiet span", int'({quiet_seen, quiet}), 2);
    held = data;
    repeat (10) @(negedge clk);
    chk(valid && data == held, "R6 hold", int'(data), int'(held));
    ready = 1'b1;
    @(negedge clk) ready = 1'b0;
    chk(!valid, "R6 accept", int'(valid), 0);
    repeat (250) @(negedge clk);
    chk(n_falls - n0 == 1, "R9 one per request", n_falls - n0, 1);
  endtask

  task automatic t_pending();
    int n0 = n_falls;
    int k = 0;
    ready = 1'b1;
    pulse_start();
    repeat (20) @(negedge clk);
    pulse_start();
    wait_valid("R11 first sample");
    chk(int'(data) == sx(12'h800), "R5 negative word", int'(data), sx(12'h800));
    while (n_falls < n0 + 2 && k < 400) begin
      @(negedge clk);
      k++;
    end
    chk(n_falls == n0 + 2, "R11 held request", n_falls - n0, 2);
    chk(last_gap == 166, "R4 R11 spacing", last_gap, 166);
    wait_valid("R11 second sample");
    chk(int'(data) == sx(word_of(model_n - 1)), "R11 second word", int'(data), sx(word_of(model_n - 1)));
    repeat (200) @(negedge clk);
  endtask

  task automatic t_free();
    ready = 1'b1;
    cs_tied = 1'b1;
    @(negedge clk);
    cs_high_seen = 0;
    free_run = 1'b1;
    for (int i = 0; i < 3; i++) begin
      wait_valid("R9 free sample");
      chk(int'(data) == sx(word_of(model_n - 1)), "R9 free word", int'(data), sx(word_of(model_n - 1)));
    end
    chk(last_gap == 166, "R4 R9 free period", last_gap, 166);
    chk(last_pw == 4, "R2 tied pulse", last_pw, 4);
    free_run = 1'b0;
    repeat (250) @(negedge clk);
    chk(!cs_high_seen, "R3 tied cs low", int'(cs_high_seen), 0);
    cs_tied = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_overrun();
    int n0 = n_falls;
    int k = 0;
    ready = 1'b0;
    free_run = 1'b1;
    while (n_falls < n0 + 2 && k < 600) begin
      @(negedge clk);
      k++;
    end
    free_run = 1'b0;
    repeat (200) @(negedge clk);
    chk(overrun && valid, "R7 overrun set", int'({overrun, valid}), 3);
    chk(int'(data) == sx(word_of(model_n - 1)), "R7 newest kept", int'(data), sx(word_of(model_n - 1)));
    ready = 1'b1;
    @(negedge clk) ready = 1'b0;
    @(negedge clk);
    chk(!valid && overrun, "R7 sticky", int'({valid, overrun}), 1);
  endtask

  task automatic t_timeout();
    int n0 = n_falls;
    model_en = 0;
    ready = 1'b1;
    pulse_start();
    repeat (150) @(negedge clk);
    chk(!timeout && quiet, "R8 not yet", int'({timeout, quiet}), 1);
    repeat (100) @(negedge clk);
    chk(timeout, "R8 flag", int'(timeout), 1);
    chk(conv_n && cs_n && !quiet && !valid, "R8 idle", int'({conv_n, cs_n, quiet, valid}), 12);
    chk(n_falls - n0 == 1, "R8 no retry", n_falls - n0, 1);
    model_en = 1;
    pulse_start();
    wait_valid("R8 recovery");
    chk(int'(data) == sx(word_of(model_n - 1)) && timeout, "R8 sticky", int'(data), sx(word_of(model_n - 1)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_pending();
    t_free();
    t_overrun();
    t_timeout();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule